// File: doc/BRIEF.md
# Memory Overlay Inhibit Controller

This block lets three memories share one 20-bit address space: a RAM that can cover the whole space, a ROM, and an auxiliary ROM. Each ROM occupies a window set by parameters. The block drives two inhibit lines. One suppresses RAM responses and the other suppresses ROM responses. For the address currently on the bus, the block also produces exactly one response enable.

Ownership of the overlaid windows depends on a phase register.

- **Loader phase.** Reset leaves the block here. A bootstrap loader in the auxiliary ROM answers inside its window.
- **Monitor phase.** Software writes a 2-bit phase code with a one-cycle strobe to reach this phase. The monitor ROM then answers inside its own window.
- **User phase.** The RAM answers everywhere.

Addresses outside every active window always go to the RAM.

Top module: `ovl_inhibit_ctrl`

## Requirements
- R1: When reset is released, the block is in the loader phase: `ram_inhibit` = 1 and `rom_inhibit` = 1.
- R2: In the loader phase, both inhibits are 1. An address inside the auxiliary window (default 0xF8000..0xFFFFF) raises `en_aux`. Any other address raises `en_ram`.
- R3: In the monitor phase, `rom_inhibit` = 0 and `ram_inhibit` = 1. An address inside the ROM window (default 0xF0000..0xFFFFF) raises `en_rom`. Any other address, including one in the auxiliary window, raises `en_ram`.
- R4: In the user phase, both inhibits are 0 and `en_ram` is raised for every address.
- R5: A cycle with `phase_wr` = 1 and `phase_code` of 2'b00 (loader), 2'b01 (monitor) or 2'b10 (user) changes the phase at the next rising clock edge. The outputs in the write cycle itself still show the old phase.
- R6: A write with `phase_code` = 2'b11 leaves the phase, the inhibits and the enables unchanged.
- R7: For every address, exactly one of `en_ram`, `en_rom` and `en_aux` is 1.
- R8: A window covers addresses from its base (inclusive) up to base plus size (exclusive). The address just below the base and the base itself fall on opposite sides of the window.
- R9: While `rst_n` is 0, both inhibits are 1 and the enables follow the loader rule without waiting for a clock edge. Reset takes priority over a phase write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces the loader view combinationally |
| phase_wr | input | 1 | One-cycle strobe that writes a phase code |
| phase_code | input | 2 | Requested phase: 00 loader, 01 monitor, 10 user, 11 ignored |
| addr | input | 20 | Address currently on the bus |
| ram_inhibit | output | 1 | 1 while the RAM is overlaid by an active ROM window |
| rom_inhibit | output | 1 | 1 while the monitor ROM must stay silent |
| en_ram | output | 1 | RAM responds to `addr` |
| en_rom | output | 1 | Monitor ROM responds to `addr` |
| en_aux | output | 1 | Auxiliary ROM responds to `addr` |

## Verification
The hardest situations to reach are two cycle-level conflicts. The first is reset falling while the registered phase still says user. The second is a phase write landing in the same cycle as reset. Neither happens in a plain bring-up sequence.

The bench drives the block into the user phase and then lowers `rst_n` in mid-cycle. It checks the inhibits before the next edge. It also issues a write together with reset.

The random phase mixes writes, ignored codes and occasional resets. It draws addresses biased toward the window edges, so each phase is exercised at both sides of both bases.

// File: rtl/ovl_pkg.sv
// Shared types for the memory overlay inhibit controller.
package ovl_pkg;
    // Phase encoding; the values match the software phase codes.
    typedef enum logic [1:0] {
        PH_LOADER  = 2'b00,
        PH_MONITOR = 2'b01,
        PH_USER    = 2'b10
    } ovl_phase_e;

    // Code that software may write but that must not change the phase.
    localparam logic [1:0] CODE_IGNORED = 2'b11;

    // Overlay windows and their index in the hit vector.
    localparam int NUM_WIN = 2;
    localparam int WIN_AUX = 0;
    localparam int WIN_ROM = 1;
endpackage

// File: rtl/ovl_phase_reg.sv
// Phase register.
// Holds the current overlay phase. A synchronous active-low reset returns it
// to the loader phase and takes priority over any write. A write loads the
// requested code at the clock edge, except the reserved code, which is dropped.
// Assumes phase_wr is a single-cycle strobe qualified by the caller.
module ovl_phase_reg
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_wr,
    input  logic [1:0] phase_code,
    output ovl_phase_e phase
);

    logic accept;

    // Accept only the three defined codes.
    always_comb begin
        accept = phase_wr && (phase_code != CODE_IGNORED);
    end

    // Phase state: reset to loader, then follow accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOADER;
        end else if (accept) begin
            phase <= ovl_phase_e'(phase_code);
        end
    end

endmodule

// File: rtl/ovl_window.sv
// Address window comparator.
// Reports whether an address lies in [BASE, BASE+SIZE). The comparison is one
// bit wider than the address, so a window that reaches the top of the space
// does not wrap. A SIZE of zero gives a window that never hits.
module ovl_window #(
    parameter int          ADDR_W = 20,
    parameter int unsigned BASE   = 0,
    parameter int unsigned SIZE   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] LO = BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] HI = BASE[ADDR_W:0] + SIZE[ADDR_W:0];

    logic [ADDR_W:0] addr_x;

    // Bounds check on the widened address.
    always_comb begin
        addr_x = {1'b0, addr};
        hit    = (addr_x >= LO) && (addr_x < HI);
    end

endmodule

// File: rtl/ovl_resp_sel.sv
// Inhibit and response selector.
// Turns the phase and the window hits into the two inhibit lines and a one-hot
// response enable. While reset is held, the loader view is forced at once,
// without waiting for the phase register to clear.
// Assumes win_hit is indexed as in ovl_pkg (WIN_AUX, WIN_ROM).
module ovl_resp_sel
    import ovl_pkg::*;
(
    input  logic               rst_n,
    input  ovl_phase_e         phase,
    input  logic [NUM_WIN-1:0] win_hit,
    output logic               ram_inhibit,
    output logic               rom_inhibit,
    output logic               en_ram,
    output logic               en_rom,
    output logic               en_aux
);

    logic loader_eff;
    logic monitor_eff;

    // Effective phase: reset overrides the register.
    always_comb begin
        loader_eff  = !rst_n || (phase == PH_LOADER);
        monitor_eff = rst_n && (phase == PH_MONITOR);
    end

    // Inhibit lines derived from the effective phase.
    always_comb begin
        rom_inhibit = loader_eff;
        ram_inhibit = loader_eff || monitor_eff;
    end

    // One responder per address: the active overlay window, else the RAM.
    always_comb begin
        en_aux = 1'b0;
        en_rom = 1'b0;
        en_ram = 1'b0;
        if (loader_eff && win_hit[WIN_AUX]) begin
            en_aux = 1'b1;
        end else if (monitor_eff && win_hit[WIN_ROM]) begin
            en_rom = 1'b1;
        end else begin
            en_ram = 1'b1;
        end
    end

endmodule

// File: rtl/ovl_inhibit_ctrl.sv
// Memory overlay inhibit controller (top).
// Owns the phase register, one comparator per overlay window, and the
// response selector. Window bases and sizes are parameters. Assumes addr is
// stable while it is being decoded. The outputs are combinational in addr and
// rst_n, and registered in the phase.
module ovl_inhibit_ctrl
    import ovl_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int unsigned AUX_BASE = 32'h000F_8000,
    parameter int unsigned AUX_SIZE = 32'h0000_8000,
    parameter int unsigned ROM_BASE = 32'h000F_0000,
    parameter int unsigned ROM_SIZE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_wr,
    input  logic [1:0]        phase_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_inhibit,
    output logic              rom_inhibit,
    output logic              en_ram,
    output logic              en_rom,
    output logic              en_aux
);

    ovl_phase_e         phase;
    logic [NUM_WIN-1:0] win_hit;

    ovl_phase_reg u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_wr   (phase_wr),
        .phase_code (phase_code),
        .phase      (phase)
    );

    // One comparator per overlay window.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int unsigned W_BASE = (w == WIN_AUX) ? AUX_BASE : ROM_BASE;
        localparam int unsigned W_SIZE = (w == WIN_AUX) ? AUX_SIZE : ROM_SIZE;
        ovl_window #(
            .ADDR_W (ADDR_W),
            .BASE   (W_BASE),
            .SIZE   (W_SIZE)
        ) u_win (
            .addr (addr),
            .hit  (win_hit[w])
        );
    end

    ovl_resp_sel u_sel (
        .rst_n       (rst_n),
        .phase       (phase),
        .win_hit     (win_hit),
        .ram_inhibit (ram_inhibit),
        .rom_inhibit (rom_inhibit),
        .en_ram      (en_ram),
        .en_rom      (en_rom),
        .en_aux      (en_aux)
    );

endmodule

// File: rtl/ovl_inhibit_chk.sv
// Protocol checker for ovl_inhibit_ctrl, attached through bind.
// Looks only at the ports of the top module.
module ovl_inhibit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phase_wr,
    input logic [1:0] phase_code,
    input logic       ram_inhibit,
    input logic       rom_inhibit,
    input logic       en_ram,
    input logic       en_rom,
    input logic       en_aux
);

    // R7
    one_responder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_ram, en_rom, en_aux}) == 1);

    // R9
    reset_forces_inhibit_chk: assert property (@(posedge clk)
        !rst_n |-> (ram_inhibit && rom_inhibit));

    // R1
    loader_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ram_inhibit && rom_inhibit));

    // R3
    rom_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_inhibit |-> !rom_inhibit);

    // R6
    ignored_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_wr && phase_code == 2'b11) |=>
            (ram_inhibit == $past(ram_inhibit) && rom_inhibit == $past(rom_inhibit)));

    // R5
    monitor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_wr && phase_code == 2'b01) |=> (ram_inhibit && !rom_inhibit));

    // R2
    aux_needs_loader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_aux |-> (ram_inhibit && rom_inhibit));

    // R4
    user_all_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_inhibit && !rom_inhibit) |-> en_ram);

endmodule

bind ovl_inhibit_ctrl ovl_inhibit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_wr    (phase_wr),
    .phase_code  (phase_code),
    .ram_inhibit (ram_inhibit),
    .rom_inhibit (rom_inhibit),
    .en_ram      (en_ram),
    .en_rom      (en_rom),
    .en_aux      (en_aux)
);

// File: tb/ovl_inhibit_ctrl_bench.sv
// Bench for ovl_inhibit_ctrl with the default parameters.
// Checks the outputs against a reference model kept in the bench.
module ovl_inhibit_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_wr = 1'b0;
    logic [1:0]  phase_code = 2'b00;
    logic [19:0] addr = 20'h0;
    logic        ram_inhibit, rom_inhibit, en_ram, en_rom, en_aux;

    int checks = 0;
    int fails  = 0;
    logic [1:0] m_phase = 2'b00;

    always #5 clk = ~clk;

    ovl_inhibit_ctrl u_ovl_inhibit_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_wr    (phase_wr),
        .phase_code  (phase_code),
        .addr        (addr),
        .ram_inhibit (ram_inhibit),
        .rom_inhibit (rom_inhibit),
        .en_ram      (en_ram),
        .en_rom      (en_rom),
        .en_aux      (en_aux)
    );

    // Expected {ram_inhibit, rom_inhibit, en_aux, en_rom, en_ram}.
    function automatic logic [4:0] expect_out(input logic rst, input logic [1:0] ph,
                                              input logic [19:0] a);
        logic ld, mon, aux_hit, rom_hit;
        logic [2:0] en;
        ld      = !rst || ph == 2'b00;
        mon     = rst && ph == 2'b01;
        aux_hit = a >= 20'hF8000;
        rom_hit = a >= 20'hF0000;
        if (ld && aux_hit)       en = 3'b100;
        else if (mon && rom_hit) en = 3'b010;
        else                     en = 3'b001;
        return {ld || mon, ld, en};
    endfunction

    task automatic check(input string req);
        logic [4:0] got, exp;
        got = {ram_inhibit, rom_inhibit, en_aux, en_rom, en_ram};
        exp = expect_out(rst_n, m_phase, addr);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%b expected=%b", req, addr, got, exp);
        end
    endtask

    // Apply inputs at the falling edge, check, then let the rising edge update the model.
    task automatic step(input logic r, input logic w, input logic [1:0] c,
                        input logic [19:0] a, input string req);
        @(negedge clk);
        rst_n = r; phase_wr = w; phase_code = c; addr = a;
        #1 check(req);
        @(posedge clk);
        if (!r) m_phase = 2'b00;
        else if (w && c != 2'b11) m_phase = c;
    endtask

    task automatic probe(input logic [19:0] a, input string req);
        step(1'b1, 1'b0, 2'b00, a, req);
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [19:0] ra;
        seed = 32'd12345;
        void'($urandom(seed));
        // R9: view during reset
        step(1'b0, 1'b0, 2'b00, 20'hF8000, "R9");
        step(1'b0, 1'b1, 2'b10, 20'h00000, "R9");
        // R1: loader after release
        probe(20'hFFFFF, "R1");
        // R2 and R8: aux window edges
        probe(20'hF7FFF, "R2 R8");
        probe(20'hF8000, "R2 R8");
        // R5: write monitor; the write cycle still shows loader
        step(1'b1, 1'b1, 2'b01, 20'hF8000, "R5");
        probe(20'hF8000, "R3 R5");
        probe(20'hEFFFF, "R3 R8");
        probe(20'hF0000, "R3 R8");
        // R6: ignored code
        step(1'b1, 1'b1, 2'b11, 20'hF0000, "R6");
        probe(20'hF0000, "R6");
        // R4: user phase
        step(1'b1, 1'b1, 2'b10, 20'h12345, "R5");
        probe(20'hF8000, "R4");
        probe(20'hF0000, "R4");
        probe(20'h00000, "R4");
        // R9: reset falls mid-cycle while in user; check before the edge
        @(negedge clk);
        rst_n = 1'b0; addr = 20'hFC000;
        #1 check("R9");
        @(posedge clk); m_phase = 2'b00;
        probe(20'hFC000, "R1");
        // Random mix, biased toward the windows
        for (int i = 0; i < 400; i++) begin
            ra = 20'($urandom);
            case ($urandom % 4)
                0: ra = 20'hF0000 | (ra & 20'h0FFFF);
                1: ra = 20'hF8000 + 20'($urandom % 4) - 20'd2;
                2: ra = 20'hF0000 + 20'($urandom % 4) - 20'd2;
                default: ;
            endcase
            step(($urandom % 40) != 0, ($urandom % 4) == 0, 2'($urandom), ra, "R7 random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule